// File: doc/BRIEF.md
# Shared Issue-Window Occupancy Accountant

This block tracks how the entries of one issue window are shared among up to four hardware threads. It holds the count of free entries, a count of entries held by each thread, and a ceiling for each thread. The ceilings come from a sharing policy that is latched while reset is held: shared-unbounded, even split, or percentage cap. Dispatch reads a global full flag and a per-thread full flag. The execution side reports entries it gives back.

Insert requests use a valid/ready handshake, one lane per thread. A lane is accepted in the cycle where both valid and ready are high. Ready is granted from the lowest thread index upward, as long as free entries remain. Ready may depend on the valid bits of lower-indexed lanes. A rejected request has no effect. The requester keeps valid high to try again. Three release strobes per thread cover these cases: issue of a non-memory instruction, completion of a memory instruction, and squash of an entry. Each strobe returns one entry.

When the active-thread mask changes, the ceilings of the active threads are recomputed. This happens at the same clock edge where the new mask is first seen.

Top module: `iq_alloc_acct`

## Requirements
- R1: The policy code is sampled while `rst` is high. The codes are 0 for shared, 1 for even split and 2 for percentage cap; 3 behaves as shared. After reset, the free count equals ENTRIES and every thread count is 0. Every ceiling starts at ENTRIES for shared, at ENTRIES/THREADS (integer division) for even split, and at ENTRIES*PCT/100 (truncated) for percentage cap. The internal copy of the mask starts as all ones.
- R2: Under the shared policy, every ceiling stays at ENTRIES whatever the mask does.
- R3: Under even split, a mask change with N>0 active threads sets each active thread's ceiling to ENTRIES/N at that edge. Inactive threads keep their ceiling. An all-zero mask changes nothing.
- R4: Under percentage cap, a mask change that leaves exactly one thread active sets that thread's ceiling to ENTRIES. Any other mask change leaves all ceilings unchanged.
- R5: `ins_ready_o[t]` is high exactly when the number of valid insert lanes below t is less than the free count. In particular, all ready bits are low when the free count is zero.
- R6: Each accepted insert lowers the free count by one and raises its thread's count by one at the next edge.
- R7: Each asserted release strobe raises the free count by one and lowers its thread's count by one. The strobes of one thread are summed with that thread's accepted insert into one net update. The releases applied are capped at the thread's count plus its accepted insert, so extra strobes are ignored.
- R8: The free count always equals ENTRIES minus the sum of the thread counts.
- R9: `full_o` is high exactly when the free count is zero. `thr_full_o[t]` is high exactly when the thread's count is at or above its ceiling.
- R10: If the mask does not change, no ceiling changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; policy sampled while high |
| policy_i | input | 2 | Sharing policy code |
| active_mask_i | input | THREADS | One bit per active thread |
| ins_valid_i | input | THREADS | Insert request per thread |
| ins_ready_o | output | THREADS | Insert accepted per thread |
| issue_i | input | THREADS | Non-memory issue release |
| mem_done_i | input | THREADS | Memory completion release |
| squash_i | input | THREADS | Squash release |
| free_total_o | output | CW | Free entries in the window |
| thr_count_o | output | THREADS*CW | Per-thread counts, thread 0 in low bits |
| thr_limit_o | output | THREADS*CW | Per-thread ceilings, thread 0 in low bits |
| full_o | output | 1 | No free entry |
| thr_full_o | output | THREADS | Thread at or above its ceiling |

## Verification
The bench builds the block with ENTRIES=16, THREADS=4 and PCT=30. With these values the even split gives ceilings of 4, 5, 8 and 16 for four, three, two and one active threads, and the percentage cap starts at 4. This is small enough that random traffic drives the window to full often. That exercises insert refusal, ceilings that fall below a thread's count, and the capping of release strobes. The bench runs each of the three policies after its own reset.

// File: rtl/iqa_pkg.sv
package iqa_pkg;
  typedef enum logic [1:0] {
    POL_SHARED = 2'd0,
    POL_SPLIT  = 2'd1,
    POL_PCT    = 2'd2
  } iqa_pol_e;
endpackage

// File: rtl/iqa_limits.sv
module iqa_limits
  import iqa_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int ENTRIES = 32,
  parameter int PCT     = 50,
  parameter int CW      = $clog2(ENTRIES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            pol_i,
  input  logic [THREADS-1:0]    mask_i,
  output logic [THREADS*CW-1:0] lim_o
);
  localparam int PCT_LIM = (ENTRIES * PCT) / 100;

  iqa_pol_e           pol_q;
  logic [THREADS-1:0] mask_q;
  logic [CW-1:0]      lim_q [THREADS];
  logic [CW-1:0]      base_lim;
  logic [CW-1:0]      split_lim;
  int                 act_n;

  always_comb begin
    case (pol_i)
      2'd1:    base_lim = CW'(ENTRIES / THREADS);
      2'd2:    base_lim = CW'(PCT_LIM);
      default: base_lim = CW'(ENTRIES);
    endcase
    act_n = 0;
    for (int t = 0; t < THREADS; t++) act_n += int'(mask_i[t]);
    split_lim = CW'(ENTRIES);
    for (int k = 1; k <= THREADS; k++)
      if (act_n == k) split_lim = CW'(ENTRIES / k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q  <= iqa_pol_e'(pol_i);
      mask_q <= '1;
      for (int t = 0; t < THREADS; t++) lim_q[t] <= base_lim;
    end else begin
      mask_q <= mask_i;
      if (mask_i != mask_q) begin
        for (int t = 0; t < THREADS; t++) begin
          if (mask_i[t]) begin
            if (pol_q == POL_SPLIT && act_n != 0) lim_q[t] <= split_lim;
            else if (pol_q == POL_PCT && act_n == 1) lim_q[t] <= CW'(ENTRIES);
          end
        end
      end
    end
  end

  for (genvar g = 0; g < THREADS; g++) begin : g_out
    assign lim_o[g*CW +: CW] = lim_q[g];
  end
endmodule

// File: rtl/iqa_thr_ctr.sv
module iqa_thr_ctr #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_i,
  input  logic [2:0]    rel_i,
  output logic [CW-1:0] cnt_o,
  output logic [1:0]    dec_o
);
  int rel_n;
  int avail;

  always_comb begin
    rel_n = int'(rel_i[0]) + int'(rel_i[1]) + int'(rel_i[2]);
    avail = int'(cnt_o) + int'(acc_i);
    dec_o = (rel_n > avail) ? 2'(avail) : 2'(rel_n);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= CW'(int'(cnt_o) + int'(acc_i) - int'(dec_o));
  end
endmodule

// File: rtl/iq_alloc_acct.sv
module iq_alloc_acct #(
  parameter int THREADS = 4,
  parameter int ENTRIES = 32,
  parameter int PCT     = 50,
  localparam int CW     = $clog2(ENTRIES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            policy_i,
  input  logic [THREADS-1:0]    active_mask_i,
  input  logic [THREADS-1:0]    ins_valid_i,
  output logic [THREADS-1:0]    ins_ready_o,
  input  logic [THREADS-1:0]    issue_i,
  input  logic [THREADS-1:0]    mem_done_i,
  input  logic [THREADS-1:0]    squash_i,
  output logic [CW-1:0]         free_total_o,
  output logic [THREADS*CW-1:0] thr_count_o,
  output logic [THREADS*CW-1:0] thr_limit_o,
  output logic                  full_o,
  output logic [THREADS-1:0]    thr_full_o
);
  logic [CW-1:0]      free_q;
  logic [THREADS-1:0] acc;
  logic [1:0]         dec [THREADS];
  int                 seen;
  int                 free_nx;

  iqa_limits #(.THREADS(THREADS), .ENTRIES(ENTRIES), .PCT(PCT), .CW(CW)) u_lim (
    .clk(clk), .rst(rst), .pol_i(policy_i), .mask_i(active_mask_i), .lim_o(thr_limit_o)
  );

  always_comb begin
    seen = 0;
    for (int t = 0; t < THREADS; t++) begin
      ins_ready_o[t] = (seen < int'(free_q));
      acc[t] = ins_valid_i[t] & ins_ready_o[t];
      seen += int'(ins_valid_i[t]);
    end
  end

  for (genvar g = 0; g < THREADS; g++) begin : g_thr
    iqa_thr_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst(rst), .acc_i(acc[g]),
      .rel_i({squash_i[g], mem_done_i[g], issue_i[g]}),
      .cnt_o(thr_count_o[g*CW +: CW]), .dec_o(dec[g])
    );
    assign thr_full_o[g] = thr_count_o[g*CW +: CW] >= thr_limit_o[g*CW +: CW];
  end

  always_comb begin
    free_nx = int'(free_q);
    for (int t = 0; t < THREADS; t++) free_nx += int'(dec[t]) - int'(acc[t]);
  end

  always_ff @(posedge clk) begin
    if (rst) free_q <= CW'(ENTRIES);
    else     free_q <= CW'(free_nx);
  end

  assign free_total_o = free_q;
  assign full_o       = (free_q == '0);
endmodule

// File: rtl/iq_alloc_acct_chk.sv
module iq_alloc_acct_chk #(
  parameter int THREADS = 4,
  parameter int ENTRIES = 32,
  parameter int CW      = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic [THREADS-1:0]    active_mask_i,
  input logic [THREADS-1:0]    ins_valid_i,
  input logic [THREADS-1:0]    ins_ready_o,
  input logic [THREADS-1:0]    issue_i,
  input logic [THREADS-1:0]    mem_done_i,
  input logic [THREADS-1:0]    squash_i,
  input logic [CW-1:0]         free_total_o,
  input logic [THREADS*CW-1:0] thr_count_o,
  input logic [THREADS*CW-1:0] thr_limit_o,
  input logic                  full_o
);
  int cnt_sum;
  always_comb begin
    cnt_sum = 0;
    for (int t = 0; t < THREADS; t++) cnt_sum += int'(thr_count_o[t*CW +: CW]);
  end

  // R8
  conservation_chk: assert property (@(posedge clk) disable iff (rst)
    int'(free_total_o) == ENTRIES - cnt_sum);

  // R5
  no_grant_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    full_o |-> ins_ready_o == '0);

  // R10
  limit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(active_mask_i) && !$past(rst)) |=> $stable(thr_limit_o));

  for (genvar g = 0; g < THREADS; g++) begin : g_c
    // R6
    insert_step_chk: assert property (@(posedge clk) disable iff (rst)
      (ins_valid_i[g] && ins_ready_o[g] && !issue_i[g] && !mem_done_i[g] && !squash_i[g])
      |=> thr_count_o[g*CW +: CW] == $past(thr_count_o[g*CW +: CW]) + CW'(1));
    // R7
    release_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!ins_valid_i[g] && thr_count_o[g*CW +: CW] != '0 &&
       $countones({issue_i[g], mem_done_i[g], squash_i[g]}) == 1)
      |=> thr_count_o[g*CW +: CW] == $past(thr_count_o[g*CW +: CW]) - CW'(1));
  end
endmodule

bind iq_alloc_acct iq_alloc_acct_chk #(.THREADS(THREADS), .ENTRIES(ENTRIES), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .active_mask_i(active_mask_i), .ins_valid_i(ins_valid_i),
  .ins_ready_o(ins_ready_o), .issue_i(issue_i), .mem_done_i(mem_done_i), .squash_i(squash_i),
  .free_total_o(free_total_o), .thr_count_o(thr_count_o), .thr_limit_o(thr_limit_o),
  .full_o(full_o)
);

// File: tb/tb_iq_alloc_acct.sv
module tb_iq_alloc_acct;
  localparam int T = 4;
  localparam int E = 16;
  localparam int P = 30;
  localparam int CW = $clog2(E + 1);

  logic clk = 0;
  logic rst = 1;
  logic [1:0] policy = 0;
  logic [T-1:0] mask = '1, vld = '0, iss = '0, mdn = '0, sq = '0;
  logic [T-1:0] rdy, tfull;
  logic [CW-1:0] free;
  logic [T*CW-1:0] cnts, lims;
  logic full;

  int checks = 0, errors = 0;
  int m_free, m_cnt[T], m_lim[T], m_pol;
  logic [T-1:0] m_mask;
  logic [T-1:0] m_rdy;

  always #10 clk = ~clk;

  iq_alloc_acct #(.THREADS(T), .ENTRIES(E), .PCT(P)) dut (
    .clk(clk), .rst(rst), .policy_i(policy), .active_mask_i(mask),
    .ins_valid_i(vld), .ins_ready_o(rdy), .issue_i(iss), .mem_done_i(mdn),
    .squash_i(sq), .free_total_o(free), .thr_count_o(cnts), .thr_limit_o(lims),
    .full_o(full), .thr_full_o(tfull)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int base_lim(input int pol);
    if (pol == 1) return E / T;
    if (pol == 2) return (E * P) / 100;
    return E;
  endfunction

  task automatic check_state(input string req);
    chk({req, " free"}, int'(free), m_free);
    chk({req, " full R9"}, int'(full), int'(m_free == 0));
    for (int t = 0; t < T; t++) begin
      chk({req, " count"}, int'(cnts[t*CW +: CW]), m_cnt[t]);
      chk({req, " limit"}, int'(lims[t*CW +: CW]), m_lim[t]);
      chk({req, " thr_full R9"}, int'(tfull[t]), int'(m_cnt[t] >= m_lim[t]));
    end
  endtask

  // advance model by one edge using current inputs; also checks ready (R5)
  task automatic step();
    int seen = 0, n = 0, nf;
    #1;
    for (int t = 0; t < T; t++) begin
      m_rdy[t] = (seen < m_free);
      if (vld[t]) seen++;
    end
    chk("R5 ready", int'(rdy), int'(m_rdy));
    nf = m_free;
    for (int t = 0; t < T; t++) begin
      int a = int'(vld[t] & m_rdy[t]);
      int r = int'(iss[t]) + int'(mdn[t]) + int'(sq[t]);
      if (r > m_cnt[t] + a) r = m_cnt[t] + a; // R7 cap
      m_cnt[t] = m_cnt[t] + a - r;
      nf = nf - a + r;
    end
    m_free = nf;
    for (int t = 0; t < T; t++) n += int'(mask[t]);
    if (mask != m_mask) begin
      for (int t = 0; t < T; t++) if (mask[t]) begin
        if (m_pol == 1 && n != 0) m_lim[t] = E / n;   // R3
        else if (m_pol == 2 && n == 1) m_lim[t] = E;  // R4
      end
    end
    m_mask = mask;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input int pol);
    @(negedge clk);
    rst = 1; policy = 2'(pol); mask = '1; vld = 0; iss = 0; mdn = 0; sq = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 0; policy = 0; // R1: later changes must not matter
    m_pol = (pol == 3) ? 0 : pol; m_free = E; m_mask = '1;
    for (int t = 0; t < T; t++) begin m_cnt[t] = 0; m_lim[t] = base_lim(pol); end
    check_state("R1 reset");
  endtask

  task automatic random_run(input int cycles, input int ins_pct, input int rel_pct);
    for (int c = 0; c < cycles; c++) begin
      for (int t = 0; t < T; t++) begin
        vld[t] = ($urandom % 100) < ins_pct;
        iss[t] = ($urandom % 100) < rel_pct;
        mdn[t] = ($urandom % 100) < rel_pct / 2;
        sq[t]  = ($urandom % 100) < rel_pct / 3;
      end
      if ($urandom % 40 == 0) mask = T'($urandom);
      step();
      check_state(m_pol == 0 ? "R2 R6 R7 R8" : (m_pol == 1 ? "R3 R6 R7 R8" : "R4 R6 R7 R8 R10"));
    end
  endtask

  initial begin
    void'($urandom(32'd12345));
    // even split, directed
    do_reset(1);
    mask = 4'b0111; vld = 0; step(); check_state("R3 three active");
    chk("R3 limit3", int'(lims[0 +: CW]), 5);
    mask = 4'b0000; step(); check_state("R3 empty mask");
    mask = 4'b1000; step(); check_state("R3 one active");
    chk("R3 limit one", int'(lims[3*CW +: CW]), 16);
    // fill to full: all lanes insert
    vld = '1;
    for (int k = 0; k < 5; k++) begin step(); check_state("R6 fill"); end
    chk("R9 full", int'(full), 1);
    step(); check_state("R5 refuse when full");
    vld = 0; iss = 4'b0001; mdn = 4'b0001; sq = 4'b0001; step(); check_state("R7 triple release");
    iss = '1; mdn = '1; sq = '1;
    for (int k = 0; k < 3; k++) begin step(); check_state("R7 drain cap"); end
    chk("R7 empty", int'(free), E);
    iss = 0; mdn = 0; sq = 0;
    random_run(3000, 50, 40);
    // shared policy
    do_reset(0);
    random_run(3000, 60, 35);
    // percentage cap
    do_reset(2);
    chk("R1 pct base", int'(lims[0 +: CW]), 4);
    mask = 4'b0010; step(); check_state("R4 single");
    chk("R4 single limit", int'(lims[CW +: CW]), 16);
    mask = 4'b0011; step(); check_state("R4 two unchanged");
    random_run(3000, 45, 40);
    // code 3 behaves as shared
    do_reset(3);
    mask = 4'b0001; step(); check_state("R2 code3");
    random_run(500, 50, 40);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule